// File: doc/BRIEF.md
# DMA channel status and interrupt controller

This block keeps the status and interrupt-enable word of one descriptor-driven DMA channel. It decides, from a small set of descriptor events, whether the channel stops, runs the same descriptor again or moves on to the next one. The data mover around it reports these events: a descriptor was fetched, whether its ownership flag was in the expected state, the level of the abort-request control bit, fly-by read mode, peripheral end-of-transfer, normal completion and error completion. The block returns a halt level, one-cycle retry and advance strobes, and a single level interrupt.

Software sees one 32-bit word. Five pending flags sit in the top bits and are cleared by writing 1. Five enable bits sit below them and can be read and written. Each stop condition has its own resume rule. A descriptor that the channel does not own holds the channel until software clears the flag, and then the same descriptor is tried again. An abort holds the channel until its flag is cleared, and then the channel moves to the next descriptor. A premature end in fly-by read mode moves on at once without stopping, and it raises the normal-completion flag as well.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The first cycle in which the block acts is therefore the third rising edge after `rst_n` goes high.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset the status word reads 0x0000_0000, `chan_halt` and `irq` are 0, and neither `desc_retry` nor `desc_advance` pulses.
- R2: The enable bits are read/write at these positions: premature-end 24, normal 23, error 22, not-owned 21, abort 20. Every other bit reads 0. A write never sets a pending bit. Writing 0xFFFF_FFFF therefore reads back 0x01F0_0000.
- R3: A fetch with `desc_own_ok`=0 sets the not-owned pending flag (bit 29) and raises `chan_halt`.
- R4: Clearing the not-owned flag drops `chan_halt` in the next cycle. One cycle later `desc_retry` pulses for exactly one cycle, and no advance is given.
- R5: A fetch with `desc_own_ok`=1 and `abort_req`=1 sets the abort pending flag (bit 28) and raises `chan_halt`. When the ownership flag is wrong, only bit 29 is set, whatever the abort level.
- R6: Clearing the abort flag produces a one-cycle `desc_advance` pulse, timed as in R4. If `abort_req` is still 1, the next fetch aborts again.
- R7: With `flyby_rd`=1, a `periph_eot` pulse in a running cycle with no fetch sets premature-end pending (bit 27) and normal pending (bit 31). `desc_advance` pulses in the next cycle and `chan_halt` stays 0. With `flyby_rd`=0, `periph_eot` has no effect.
- R8: `xfer_done` sets normal pending (bit 31) and `xfer_err` sets error pending (bit 30). Neither halts the channel or pulses a strobe.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R10: `irq` is high exactly when some pending bit and its matching enable are both 1.
- R11: While the channel is halted, the fetch, end-of-transfer, completion and error events are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | One-cycle strobe: a descriptor was fetched |
| desc_own_ok | input | 1 | Ownership flag of the fetched descriptor is in the expected state |
| abort_req | input | 1 | Level of the abort-request control bit |
| flyby_rd | input | 1 | Channel is in fly-by read mode |
| periph_eot | input | 1 | Peripheral end-of-transfer strobe |
| xfer_done | input | 1 | Normal completion strobe |
| xfer_err | input | 1 | Error completion strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status/enable word |
| chan_halt | output | 1 | Channel is held by a not-owned or abort condition |
| desc_retry | output | 1 | One-cycle strobe: fetch the same descriptor again |
| desc_advance | output | 1 | One-cycle strobe: go to the next descriptor |
| irq | output | 1 | Level interrupt |

## Verification
The block is tried with bad-ownership fetches, with aborting fetches, with both arriving together, and with end-of-transfer both with and without fly-by mode. Each stop is then released through a register clear. A scoreboard of expected retry and advance strobes tells apart the same-descriptor resume from the next-descriptor resume. It also catches pulses that are stretched or that should not occur. Clears are also raced against hardware sets, and events are injected while the channel is halted, to separate the priority rule and the halted gating from plain clear behaviour.

// File: rtl/dma_chan_stat_pkg.sv
package dma_chan_stat_pkg;

  // Pending/enable source indices
  localparam int unsigned NSRC   = 5;
  localparam int unsigned SRC_NC = 0;  // normal completion
  localparam int unsigned SRC_EC = 1;  // error completion
  localparam int unsigned SRC_NR = 2;  // descriptor not owned
  localparam int unsigned SRC_CA = 3;  // channel abort
  localparam int unsigned SRC_PC = 4;  // premature end

  // Pending flags occupy bits 31 down to 27
  function automatic int unsigned pend_bit(input int unsigned s);
    return 32'd31 - s;
  endfunction

  function automatic int unsigned en_bit(input int unsigned s);
    case (s)
      SRC_NC:  return 32'd23;
      SRC_EC:  return 32'd22;
      SRC_NR:  return 32'd21;
      SRC_CA:  return 32'd20;
      default: return 32'd24;
    endcase
  endfunction

  function automatic logic [31:0] used_mask();
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      m[pend_bit(i)] = 1'b1;
      m[en_bit(i)]   = 1'b1;
    end
    return m;
  endfunction

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HOLD_NR = 2'd1,
    ST_HOLD_AB = 2'd2
  } chan_state_e;

endpackage

// File: rtl/dma_chan_stat_rstsync.sv
module dma_chan_stat_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dma_chan_stat_seq.sv
module dma_chan_stat_seq
  import dma_chan_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            desc_valid,
  input  logic            desc_own_ok,
  input  logic            abort_req,
  input  logic            flyby_rd,
  input  logic            periph_eot,
  input  logic            xfer_done,
  input  logic            xfer_err,
  input  logic            nr_pend,
  input  logic            ab_pend,
  output logic [NSRC-1:0] set_vec,
  output logic            desc_retry,
  output logic            desc_advance
);

  chan_state_e state_q, state_d;
  logic        retry_d, adv_d;
  logic        run, fetch_bad, fetch_abort, early_end;

  // Event decode; everything is gated off unless the channel runs
  always_comb begin
    run         = (state_q == ST_RUN);
    fetch_bad   = run & desc_valid & ~desc_own_ok;
    fetch_abort = run & desc_valid & desc_own_ok & abort_req;
    early_end   = run & ~desc_valid & flyby_rd & periph_eot;

    set_vec         = '0;
    set_vec[SRC_NR] = fetch_bad;
    set_vec[SRC_CA] = fetch_abort;
    set_vec[SRC_PC] = early_end;
    set_vec[SRC_NC] = early_end | (run & xfer_done);
    set_vec[SRC_EC] = run & xfer_err;
  end

  // Next state and strobe decisions
  always_comb begin
    state_d = state_q;
    retry_d = 1'b0;
    adv_d   = early_end;
    case (state_q)
      ST_RUN: begin
        if (fetch_bad) begin
          state_d = ST_HOLD_NR;
        end else if (fetch_abort) begin
          state_d = ST_HOLD_AB;
        end
      end
      ST_HOLD_NR: begin
        if (!nr_pend) begin
          state_d = ST_RUN;
          retry_d = 1'b1;
        end
      end
      ST_HOLD_AB: begin
        if (!ab_pend) begin
          state_d = ST_RUN;
          adv_d   = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      desc_retry   <= 1'b0;
      desc_advance <= 1'b0;
    end else begin
      state_q      <= state_d;
      desc_retry   <= retry_d;
      desc_advance <= adv_d;
    end
  end

  // A bad-ownership fetch parks the sequencer with the flag raised
  p_bad_own_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && desc_valid && !desc_own_ok) |=> (state_q == ST_HOLD_NR && nr_pend));

  p_retry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_retry |=> !desc_retry);

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_retry && desc_advance));

  // Halted channel takes no new events
  p_halted_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> (set_vec == '0));

endmodule

// File: rtl/dma_chan_stat_regs.sv
module dma_chan_stat_regs
  import dma_chan_stat_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  set_vec,
  output logic [NSRC-1:0]  pend_q,
  output logic [NSRC-1:0]  en_q,
  output logic [REG_W-1:0] rdata
);

  localparam logic [REG_W-1:0] USED = REG_W'(used_mask());

  logic [NSRC-1:0] clr_vec, pend_d, en_d;
  logic            unused_wbits;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign clr_vec[g] = wr_en & wdata[pend_bit(g)];
      assign en_d[g]    = wdata[en_bit(g)];
    end
  endgenerate

  assign unused_wbits = ^(wdata & ~USED);

  // Hardware set overrides a simultaneous write-1 clear
  always_comb begin
    pend_d = set_vec | (pend_q & ~clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      rdata[pend_bit(i)] = pend_q[i];
      rdata[en_bit(i)]   = en_q[i];
    end
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

endmodule

// File: rtl/dma_chan_stat_irq.sv
module dma_chan_stat_irq
  import dma_chan_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output logic            irq
);

  logic [NSRC-1:0] hit;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_hit
      assign hit[g] = pend[g] & en[g];
    end
  endgenerate

  assign irq = |hit;

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
  import dma_chan_stat_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  input  logic             desc_own_ok,
  input  logic             abort_req,
  input  logic             flyby_rd,
  input  logic             periph_eot,
  input  logic             xfer_done,
  input  logic             xfer_err,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             chan_halt,
  output logic             desc_retry,
  output logic             desc_advance,
  output logic             irq
);

  logic            rst_sync_n;
  logic [NSRC-1:0] set_vec, pend_q, en_q;

  dma_chan_stat_rstsync #(.STAGES(SYNC_STAGES)) i_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_chan_stat_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .desc_valid   (desc_valid),
    .desc_own_ok  (desc_own_ok),
    .abort_req    (abort_req),
    .flyby_rd     (flyby_rd),
    .periph_eot   (periph_eot),
    .xfer_done    (xfer_done),
    .xfer_err     (xfer_err),
    .nr_pend      (pend_q[SRC_NR]),
    .ab_pend      (pend_q[SRC_CA]),
    .set_vec      (set_vec),
    .desc_retry   (desc_retry),
    .desc_advance (desc_advance)
  );

  dma_chan_stat_regs #(.REG_W(REG_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .set_vec (set_vec),
    .pend_q  (pend_q),
    .en_q    (en_q),
    .rdata   (reg_rdata)
  );

  dma_chan_stat_irq i_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pend  (pend_q),
    .en    (en_q),
    .irq   (irq)
  );

  assign chan_halt = pend_q[SRC_NR] | pend_q[SRC_CA];

  // Clearing the not-owned flag must lead to a retry strobe
  p_retry_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(pend_q[SRC_NR]) |=> desc_retry);

  p_advance_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(pend_q[SRC_CA]) |=> desc_advance);

  p_early_end_sets_nc_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    set_vec[SRC_PC] |=> (pend_q[SRC_PC] && pend_q[SRC_NC] && desc_advance && !chan_halt));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!desc_retry && !desc_advance && !irq && !chan_halt));

endmodule

// File: tb/test_dma_chan_stat.sv
module test_dma_chan_stat;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [31:0] B_NC = 32'h8000_0000;
  localparam logic [31:0] B_EC = 32'h4000_0000;
  localparam logic [31:0] B_NR = 32'h2000_0000;
  localparam logic [31:0] B_CA = 32'h1000_0000;
  localparam logic [31:0] B_PC = 32'h0800_0000;
  localparam logic [31:0] E_NC = 32'h0080_0000;
  localparam logic [31:0] E_NR = 32'h0020_0000;

  typedef enum logic {EXP_RETRY = 1'b0, EXP_ADV = 1'b1} pulse_e;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_valid, desc_own_ok, abort_req, flyby_rd;
  logic        periph_eot, xfer_done, xfer_err, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        chan_halt, desc_retry, desc_advance, irq;

  int     n_chk  = 0;
  int     n_fail = 0;
  pulse_e exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_stat i_dma_chan_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_valid   (desc_valid),
    .desc_own_ok  (desc_own_ok),
    .abort_req    (abort_req),
    .flyby_rd     (flyby_rd),
    .periph_eot   (periph_eot),
    .xfer_done    (xfer_done),
    .xfer_err     (xfer_err),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .chan_halt    (chan_halt),
    .desc_retry   (desc_retry),
    .desc_advance (desc_advance),
    .irq          (irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic fetch(input logic own, input logic ab);
    @(negedge clk);
    desc_valid = 1'b1; desc_own_ok = own; abort_req = ab;
    @(negedge clk);
    desc_valid = 1'b0; desc_own_ok = 1'b1;
  endtask

  task automatic pulse_eot();
    @(negedge clk);
    periph_eot = 1'b1;
    @(negedge clk);
    periph_eot = 1'b0;
  endtask

  task automatic pulse_done_err(input logic d, input logic e);
    @(negedge clk);
    xfer_done = d; xfer_err = e;
    @(negedge clk);
    xfer_done = 1'b0; xfer_err = 1'b0;
  endtask

  // Monitor: compares every retry/advance strobe with the scoreboard (R4, R6, R7)
  always @(negedge clk) begin
    if (rst_n && (desc_retry || desc_advance)) begin
      n_chk++;
      if (desc_retry && desc_advance) begin
        n_fail++;
        $display("FAIL R6: both strobes high, got retry=1 advance=1 expected one");
      end else if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7: unexpected strobe retry=%0b advance=%0b expected none",
                 desc_retry, desc_advance);
      end else begin
        pulse_e want;
        pulse_e seen;
        want = exp_q.pop_front();
        seen = desc_advance ? EXP_ADV : EXP_RETRY;
        if (seen != want) begin
          n_fail++;
          $display("FAIL R4: strobe kind got %s expected %s", seen.name(), want.name());
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    desc_valid = 1'b0; desc_own_ok = 1'b1; abort_req = 1'b0; flyby_rd = 1'b0;
    periph_eot = 1'b0; xfer_done = 1'b0; xfer_err = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 status word", reg_rdata, 32'h0);
    check("R1 halt", {31'd0, chan_halt}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 register map
    write_reg(32'hFFFF_FFFF);
    check("R2 enables only", reg_rdata, 32'h01F0_0000);
    write_reg(32'h0);
    check("R2 cleared", reg_rdata, 32'h0);

    // R8 completion and error flags
    pulse_done_err(1'b1, 1'b0);
    check("R8 normal flag", reg_rdata, B_NC);
    pulse_done_err(1'b0, 1'b1);
    check("R8 error flag", reg_rdata, B_NC | B_EC);
    check("R8 no halt", {31'd0, chan_halt}, 32'd0);

    // R10 interrupt gating
    check("R10 irq disabled", {31'd0, irq}, 32'd0);
    write_reg(E_NC);
    check("R10 irq enabled", {31'd0, irq}, 32'd1);
    write_reg(E_NC | B_NC);
    check("R9 clear normal", reg_rdata, B_EC | E_NC);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);
    write_reg(E_NC);
    check("R9 zero keeps", reg_rdata, B_EC | E_NC);

    // R9 hardware set beats clear
    @(negedge clk);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_wdata = B_NC | B_EC | E_NC;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    check("R9 set wins", reg_rdata, B_NC | E_NC);
    check("R10 irq from race", {31'd0, irq}, 32'd1);
    write_reg(B_NC);
    check("R9 all clear", reg_rdata, 32'h0);

    // R3 not-owned fetch
    fetch(1'b0, 1'b0);
    check("R3 not-owned flag", reg_rdata, B_NR);
    check("R3 halt", {31'd0, chan_halt}, 32'd1);
    write_reg(E_NR);
    check("R10 irq not-owned", {31'd0, irq}, 32'd1);

    // R11 events ignored while halted
    fetch(1'b1, 1'b1);
    flyby_rd = 1'b1;
    pulse_eot();
    flyby_rd = 1'b0;
    pulse_done_err(1'b1, 1'b1);
    check("R11 halted ignores", reg_rdata, B_NR | E_NR);

    // R4 retry after clear
    exp_q.push_back(EXP_RETRY);
    write_reg(B_NR);
    check("R4 halt drops", {31'd0, chan_halt}, 32'd0);
    check("R4 flag cleared", reg_rdata, 32'h0);
    idle(4);

    // R5 ownership takes precedence over abort
    fetch(1'b0, 1'b1);
    check("R5 precedence", reg_rdata, B_NR);
    exp_q.push_back(EXP_RETRY);
    write_reg(B_NR);
    idle(4);

    // R5 abort
    fetch(1'b1, 1'b1);
    check("R5 abort flag", reg_rdata, B_CA);
    check("R5 halt", {31'd0, chan_halt}, 32'd1);

    // R6 advance after clear, abort still requested
    exp_q.push_back(EXP_ADV);
    write_reg(B_CA);
    check("R6 halt drops", {31'd0, chan_halt}, 32'd0);
    idle(4);
    fetch(1'b1, 1'b1);
    check("R6 aborts again", reg_rdata, B_CA);
    abort_req = 1'b0;
    exp_q.push_back(EXP_ADV);
    write_reg(B_CA);
    idle(4);
    fetch(1'b1, 1'b0);
    check("R6 clean fetch", reg_rdata, 32'h0);
    check("R6 runs", {31'd0, chan_halt}, 32'd0);

    // R7 premature end in fly-by mode
    flyby_rd = 1'b1;
    exp_q.push_back(EXP_ADV);
    pulse_eot();
    check("R7 premature flags", reg_rdata, B_NC | B_PC);
    check("R7 no halt", {31'd0, chan_halt}, 32'd0);
    idle(3);
    write_reg(B_NC | B_PC);
    flyby_rd = 1'b0;
    pulse_eot();
    check("R7 no effect outside fly-by", reg_rdata, 32'h0);
    idle(4);

    check("R6 scoreboard drained", exp_q.size(), 32'd0);
    summary();
    $finish;
  end

endmodule